// File: doc/BRIEF.md
# Flash Buffered-Write Command Controller

This block sits between a simple synchronous bus slave and a byte-wide NOR-style flash array port, and runs the buffered block-program command sequence. A bus write of the buffered-program opcode arms the sequence. The next write supplies a word count and, through its address, selects one aligned write block. The controller then copies that block from the array into a staging buffer. The following data writes go into the staging buffer only. The array is touched again only when a valid confirm arrives: the whole buffer is then written back as one burst. An abort or an error throws the buffer away and leaves the array as it was.

Outside the sequence the controller accepts three single-cycle commands: select array reads, select status reads and clear the error flag. Bus reads return either the array byte at the bus address or the status byte. The status byte has bit 7 as the ready flag and bit 4 as the sticky program-error flag. The bus slave drops `bus_ready` while the block is copied in or written back. The write block size, address width, count width and byte order are parameters.

States: IDLE (command decode), COUNT (wait for the count write), FILL (copy the block into the buffer), DATA (accept data writes), CONFIRM (wait for confirm or abort), COMMIT (write the buffer back). Transitions: IDLE to COUNT on opcode 0xE8. COUNT to FILL on the count write. FILL to DATA after the last block byte. DATA to CONFIRM on the data write taken with the counter at zero. CONFIRM to COMMIT on 0xD0 with the error flag clear. CONFIRM to IDLE on any other write. COMMIT to IDLE after the last beat.

Top module: `flash_bufwr_ctrl`

## Requirements
- R1: After reset, `bus_ready` is 1, bus reads return the array byte at `bus_addr` in bits 7:0, and after command 0x70 the read data is 0x80.
- R2: The count write sets the block base to its address with the low log2(BLK_BYTES) bits cleared. `bus_ready` is then low for exactly BLK_BYTES cycles while the block is copied in. Block bytes that are not written during the data phase keep their array values through a commit.
- R3: Only the low COUNT_W bits of the count write are used; a count N gives N+1 data writes, after which the next write is treated as the confirm step.
- R4: A data-phase write is placed in the buffer at (address − base), and the array is not modified before the confirm.
- R5: A data write whose first byte lies below the base, or whose last byte lies past base + BLK_BYTES − 1, sets status bit 4 and is dropped. The bit stays set until command 0x50.
- R6: `bus_size` selects the write width (0 = byte, 1 = halfword, 2 or 3 = word). With the default byte order, bits 8k+7:8k go to address + k.
- R7: Command 0xD0 in the confirm step with bit 4 clear writes the buffer to the array as BLK_BYTES consecutive beats. `bus_ready` is low during those beats, and afterwards the status reads 0x80.
- R8: Any write other than 0xD0 in the confirm step discards the buffer, leaves the array unchanged and switches reads to the array.
- R9: Command 0xD0 in the confirm step with bit 4 set also discards the buffer, leaves the array unchanged and switches reads to the array.
- R10: A data write while `wp` is high sets status bit 4 and does not reach the buffer.
- R11: In IDLE, command 0x50 clears bit 4, 0x70 selects status reads and 0xFF selects array reads.
- R12: Status bit 7 reads 0 whenever `bus_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp | input | 1 | Write protect; data writes fail while high |
| bus_addr | input | AW | Bus byte address |
| bus_wdata | input | 32 | Bus write data (commands in bits 7:0) |
| bus_size | input | 2 | Write width: 0 byte, 1 halfword, 2/3 word |
| bus_we | input | 1 | Write request, held until taken while `bus_ready` is high |
| bus_rdata | output | 32 | Array byte or status byte, zero-extended |
| bus_ready | output | 1 | Low while the block is copied in or written back |
| arr_addr | output | AW | Array byte address |
| arr_we | output | 1 | Array write strobe |
| arr_wdata | output | 8 | Array write byte |
| arr_rdata | input | 8 | Array read byte for `arr_addr`, same cycle |

## Verification
The assertions assume that a bus master holds a write until it is taken with `bus_ready` high. They also assume that `arr_rdata` follows `arr_addr` in the same cycle. The bench issues every write through one task, which waits for `bus_ready` before the write is counted as taken. The bench's array model is a combinational-read memory, so both assumptions hold. Random bursts choose offsets and sizes that keep every write inside its block. Error cases are produced only by directed sequences, so the sticky error flag stays clear during the random phase.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
    localparam int BUS_DW = 32;

    localparam logic [7:0] CMD_BUFPROG  = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
    localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_RD_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR_ERR  = 8'h50;

    localparam int STAT_RDY_BIT = 7;
    localparam int STAT_ERR_BIT = 4;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COUNT   = 3'd1,
        ST_FILL    = 3'd2,
        ST_DATA    = 3'd3,
        ST_CONFIRM = 3'd4,
        ST_COMMIT  = 3'd5
    } fbw_state_e;
endpackage

// File: rtl/fbw_lane_steer.sv
module fbw_lane_steer #(
    parameter bit BIG_END = 1'b0
) (
    input  logic [1:0]                  size,
    input  logic [fbw_pkg::BUS_DW-1:0]  wdata,
    output logic [2:0]                  nbytes,
    output logic [fbw_pkg::BUS_DW-1:0]  lanes
);
    // lanes[8k+:8] is the byte destined for start address + k
    always_comb begin
        unique case (size)
            2'b00:   nbytes = 3'd1;
            2'b01:   nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
    end

    generate
        if (BIG_END) begin : g_big
            always_comb begin
                unique case (size)
                    2'b00:   lanes = {24'h0, wdata[7:0]};
                    2'b01:   lanes = {16'h0, wdata[7:0], wdata[15:8]};
                    default: lanes = {wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24]};
                endcase
            end
        end else begin : g_little
            assign lanes = wdata;
        end
    endgenerate
endmodule

// File: rtl/fbw_stage_buf.sv
module fbw_stage_buf #(
    parameter int BLK_BYTES = 16,
    localparam int IDX_W    = $clog2(BLK_BYTES)
) (
    input  logic                        clk,
    input  logic                        fill_we,
    input  logic [IDX_W-1:0]            fill_idx,
    input  logic [7:0]                  fill_byte,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_off,
    input  logic [2:0]                  wr_n,
    input  logic [fbw_pkg::BUS_DW-1:0]  wr_lanes,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [7:0]                  rd_byte
);
    logic [7:0] mem_q [BLK_BYTES];
    logic [BLK_BYTES-1:0] hit;
    logic [7:0] val [BLK_BYTES];

    // Map each incoming lane onto the buffer byte it covers
    always_comb begin
        for (int j = 0; j < BLK_BYTES; j++) begin
            hit[j] = 1'b0;
            val[j] = 8'h00;
            for (int k = 0; k < 4; k++) begin
                if ((3'(k) < wr_n) &&
                    (({1'b0, wr_off} + (IDX_W+1)'(k)) == (IDX_W+1)'(j))) begin
                    hit[j] = 1'b1;
                    val[j] = wr_lanes[8*k +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < BLK_BYTES; j++) begin
            if (fill_we && (fill_idx == IDX_W'(j))) begin
                mem_q[j] <= fill_byte;
            end else if (wr_en && hit[j]) begin
                mem_q[j] <= val[j];
            end
        end
    end

    assign rd_byte = mem_q[rd_idx];
endmodule

// File: rtl/fbw_cmd_fsm.sv
module fbw_cmd_fsm
    import fbw_pkg::*;
#(
    parameter int AW        = 12,
    parameter int BLK_BYTES = 16,
    parameter int COUNT_W   = 8,
    localparam int IDX_W    = $clog2(BLK_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wp,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [7:0]         cmd_byte,
    input  logic [COUNT_W-1:0] cnt_val,
    input  logic [2:0]         nbytes,
    output logic               bus_ready,
    output logic               rd_array,
    output logic [7:0]         status,
    output logic [AW-1:0]      arr_addr,
    output logic               arr_we,
    output logic               fill_we,
    output logic               buf_we,
    output logic [IDX_W-1:0]   buf_off,
    output logic [IDX_W-1:0]   beat_idx,
    output fbw_state_e         state,
    output logic [AW-1:0]      base
);
    localparam logic [AW-1:0]  BASE_NONE = '1;
    localparam logic [AW-1:0]  ALIGN_MASK = ~AW'(BLK_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);

    fbw_state_e        state_q, state_d;
    logic [AW-1:0]     base_q;
    logic [COUNT_W-1:0] cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic              rdy_q, err_q, rdarr_q;

    logic              take;
    logic              buf_valid;
    logic              in_blk;
    logic [AW:0]       wr_lo, wr_hi, blk_lo, blk_hi;
    logic              data_ok;
    logic              do_commit;

    assign take      = bus_we && bus_ready;
    assign buf_valid = (base_q != BASE_NONE);

    always_comb begin
        wr_lo  = {1'b0, bus_addr};
        wr_hi  = wr_lo + (AW+1)'(nbytes);
        blk_lo = {1'b0, base_q};
        blk_hi = blk_lo + (AW+1)'(BLK_BYTES);
        in_blk = (wr_lo >= blk_lo) && (wr_hi <= blk_hi);
    end

    assign data_ok   = !wp && buf_valid && in_blk;
    assign do_commit = (cmd_byte == CMD_CONFIRM) && !err_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take && cmd_byte == CMD_BUFPROG) state_d = ST_COUNT;
            ST_COUNT:   if (take) state_d = ST_FILL;
            ST_FILL:    if (idx_q == LAST_IDX) state_d = ST_DATA;
            ST_DATA:    if (take && cnt_q == '0) state_d = ST_CONFIRM;
            ST_CONFIRM: if (take) state_d = do_commit ? ST_COMMIT : ST_IDLE;
            ST_COMMIT:  if (idx_q == LAST_IDX) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= BASE_NONE;
            cnt_q   <= '0;
            idx_q   <= '0;
            rdy_q   <= 1'b1;
            err_q   <= 1'b0;
            rdarr_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        if (cmd_byte == CMD_BUFPROG)  rdarr_q <= 1'b0;
                        if (cmd_byte == CMD_RD_STAT)  rdarr_q <= 1'b0;
                        if (cmd_byte == CMD_RD_ARRAY) rdarr_q <= 1'b1;
                        if (cmd_byte == CMD_CLR_ERR)  err_q   <= 1'b0;
                    end
                end
                ST_COUNT: begin
                    if (take) begin
                        cnt_q  <= cnt_val;
                        base_q <= bus_addr & ALIGN_MASK;
                        idx_q  <= '0;
                        rdy_q  <= 1'b0;
                    end
                end
                ST_FILL: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_IDX) rdy_q <= 1'b1;
                end
                ST_DATA: begin
                    if (take) begin
                        rdy_q <= 1'b1;
                        if (!data_ok) err_q <= 1'b1;
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_CONFIRM: begin
                    if (take) begin
                        if (do_commit) begin
                            idx_q <= '0;
                            rdy_q <= 1'b0;
                        end else begin
                            base_q  <= BASE_NONE;
                            rdarr_q <= 1'b1;
                        end
                    end
                end
                ST_COMMIT: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_IDX) begin
                        base_q <= BASE_NONE;
                        rdy_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        bus_ready = 1'b1;
        arr_we    = 1'b0;
        fill_we   = 1'b0;
        buf_we    = 1'b0;
        arr_addr  = bus_addr;
        unique case (state_q)
            ST_FILL: begin
                bus_ready = 1'b0;
                fill_we   = 1'b1;
                arr_addr  = base_q + AW'(idx_q);
            end
            ST_COMMIT: begin
                bus_ready = 1'b0;
                arr_we    = 1'b1;
                arr_addr  = base_q + AW'(idx_q);
            end
            ST_DATA: buf_we = take && data_ok;
            default: ;
        endcase
    end

    assign buf_off  = IDX_W'(bus_addr - base_q);
    assign beat_idx = idx_q;
    assign rd_array = rdarr_q;
    assign status   = {rdy_q, 2'b00, err_q, 4'b0000};
    assign state    = state_q;
    assign base     = base_q;
endmodule

// File: rtl/flash_bufwr_ctrl.sv
module flash_bufwr_ctrl
    import fbw_pkg::*;
#(
    parameter int AW        = 12,
    parameter int BLK_BYTES = 16,
    parameter int COUNT_W   = 8,
    parameter bit BIG_END   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp,
    input  logic [AW-1:0]     bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              bus_ready,
    output logic [AW-1:0]     arr_addr,
    output logic              arr_we,
    output logic [7:0]        arr_wdata,
    input  logic [7:0]        arr_rdata
);
    localparam int IDX_W = $clog2(BLK_BYTES);

    logic [7:0]        cmd_w;
    logic [2:0]        nbytes_w;
    logic [BUS_DW-1:0] lanes_w;
    logic              rdarr_w;
    logic [7:0]        status_w;
    logic              fill_we_w, buf_we_w;
    logic [IDX_W-1:0]  buf_off_w, beat_w;
    fbw_state_e        state_w;
    logic [AW-1:0]     base_w;

    assign cmd_w = bus_wdata[7:0];

    fbw_lane_steer #(.BIG_END(BIG_END)) u_lane (
        .size   (bus_size),
        .wdata  (bus_wdata),
        .nbytes (nbytes_w),
        .lanes  (lanes_w)
    );

    fbw_cmd_fsm #(.AW(AW), .BLK_BYTES(BLK_BYTES), .COUNT_W(COUNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wp        (wp),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .cmd_byte  (cmd_w),
        .cnt_val   (bus_wdata[COUNT_W-1:0]),
        .nbytes    (nbytes_w),
        .bus_ready (bus_ready),
        .rd_array  (rdarr_w),
        .status    (status_w),
        .arr_addr  (arr_addr),
        .arr_we    (arr_we),
        .fill_we   (fill_we_w),
        .buf_we    (buf_we_w),
        .buf_off   (buf_off_w),
        .beat_idx  (beat_w),
        .state     (state_w),
        .base      (base_w)
    );

    fbw_stage_buf #(.BLK_BYTES(BLK_BYTES)) u_buf (
        .clk       (clk),
        .fill_we   (fill_we_w),
        .fill_idx  (beat_w),
        .fill_byte (arr_rdata),
        .wr_en     (buf_we_w),
        .wr_off    (buf_off_w),
        .wr_n      (nbytes_w),
        .wr_lanes  (lanes_w),
        .rd_idx    (beat_w),
        .rd_byte   (arr_wdata)
    );

    assign bus_rdata = rdarr_w ? {{(BUS_DW-8){1'b0}}, arr_rdata}
                               : {{(BUS_DW-8){1'b0}}, status_w};
endmodule

// File: rtl/fbw_checker.sv
module fbw_checker
    import fbw_pkg::*;
#(
    parameter int AW        = 12,
    parameter int BLK_BYTES = 16,
    localparam int IDX_W    = $clog2(BLK_BYTES),
    localparam int RUN_W    = IDX_W + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic [7:0]    cmd_w,
    input logic          bus_ready,
    input logic          arr_we,
    input fbw_state_e    state_w,
    input logic [AW-1:0] base_w,
    input logic [7:0]    status_w
);
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (arr_we) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    // R7: array writes only happen while the bus is stalled
    assert_stall_on_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !bus_ready);

    // R7: each write-back burst is exactly one block long
    assert_burst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_we) |-> (run_q == RUN_W'(BLK_BYTES)));

    // R2: a live buffer always has a valid base
    assert_base_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_DATA || state_w == ST_CONFIRM || state_w == ST_COMMIT)
        |-> (base_w != '1));

    // R2: a valid base is block aligned
    assert_base_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (base_w != '1) |-> (base_w[IDX_W-1:0] == '0));

    // R5: the error flag only clears on the clear command in IDLE
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_w[STAT_ERR_BIT]) |->
        $past(bus_we && bus_ready && cmd_w == CMD_CLR_ERR && state_w == ST_IDLE));

    // R12: ready flag is low while the bus is stalled
    assert_rdy_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |-> !status_w[STAT_RDY_BIT]);
endmodule

bind flash_bufwr_ctrl fbw_checker #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_chk (.*);

// File: tb/flash_bufwr_ctrl_tb.sv
module flash_bufwr_ctrl_tb;
    localparam int AW   = 12;
    localparam int BLK  = 16;
    localparam int ASZ  = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [AW-1:0] arr_addr;
    logic        arr_we;
    logic [7:0]  arr_wdata;
    logic [7:0]  arr_rdata;

    logic [7:0] mem [ASZ];
    logic [7:0] exp_mem [ASZ];
    logic [7:0] tbuf [BLK];

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    flash_bufwr_ctrl #(.AW(AW), .BLK_BYTES(BLK), .COUNT_W(8), .BIG_END(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .wp(wp),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .arr_addr(arr_addr), .arr_we(arr_we), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata)
    );

    function automatic logic [7:0] pat(int i);
        return 8'(i * 13 + 5);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ASZ; i++) mem[i] <= pat(i);
        end else if (arr_we) begin
            mem[arr_addr] <= arr_wdata;
        end
    end
    assign arr_rdata = mem[arr_addr];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [1:0] s);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_size = s; bus_we = 1'b1;
        while (!bus_ready) @(negedge clk);
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] c);
        wr('0, {24'h0, c}, 2'b00);
    endtask

    task automatic busy(output int n);
        n = 0;
        while (!bus_ready) begin
            n++;
            @(posedge clk);
            #1;
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata[7:0];
    endtask

    // Start a sequence: opcode, count write at a, load the bench copy of the block
    task automatic start_blk(input logic [AW-1:0] a, input logic [31:0] cnt, output int n);
        logic [AW-1:0] b;
        cmd(8'hE8);
        wr(a, cnt, 2'b10);
        b = a & ~AW'(BLK - 1);
        for (int i = 0; i < BLK; i++) tbuf[i] = exp_mem[int'(b) + i];
        busy(n);
    endtask

    task automatic apply(input int off, input logic [31:0] d, input int nb);
        for (int k = 0; k < nb; k++) tbuf[off + k] = d[8*k +: 8];
    endtask

    task automatic cmp_blk(input string req, input logic [AW-1:0] b);
        int diffs = 0;
        for (int i = 0; i < BLK; i++)
            if (mem[int'(b) + i] !== exp_mem[int'(b) + i]) diffs++;
        chk(req, diffs, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] v;
        int unsigned r;
        for (int i = 0; i < ASZ; i++) exp_mem[i] = pat(i);
        r = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk("R1 ready", 32'(bus_ready), 1);
        rd(12'h045, v);
        chk("R1 array read", 32'(v), 32'(pat(12'h045)));
        cmd(8'h70);
        chk("R1 status", bus_rdata, 32'h80);

        // R2 R4 R6 R7: normal commit with word, halfword, byte
        cmd(8'hFF);
        start_blk(12'h123, 32'd2, n);
        chk("R2 fill stall", 32'(n), BLK);
        wr(12'h124, 32'hA1B2C3D4, 2'b10); apply(4, 32'hA1B2C3D4, 4);
        chk("R12 R2 status after data", bus_rdata, 32'h80);
        wr(12'h12A, 32'h00007788, 2'b01); apply(10, 32'h00007788, 2);
        wr(12'h12F, 32'h0000005A, 2'b00); apply(15, 32'h5A, 1);
        chk("R4 array untouched", 32'(mem[12'h124]), 32'(pat(12'h124)));
        cmd(8'hD0);
        busy(n);
        chk("R7 commit stall", 32'(n), BLK);
        chk("R7 status after commit", bus_rdata, 32'h80);
        for (int i = 0; i < BLK; i++) exp_mem[12'h120 + i] = tbuf[i];
        cmd(8'hFF);
        rd(12'h124, v); chk("R6 word byte0", 32'(v), 32'hD4);
        rd(12'h127, v); chk("R6 word byte3", 32'(v), 32'hA1);
        rd(12'h12B, v); chk("R6 half byte1", 32'(v), 32'h77);
        rd(12'h121, v); chk("R2 unwritten byte kept", 32'(v), 32'(pat(12'h121)));
        cmp_blk("R4 block after commit", 12'h120);

        // R3: count masked to 8 bits (0x102 -> 3 writes)
        start_blk(12'h507, 32'h102, n);
        wr(12'h500, 32'h11, 2'b00); apply(0, 32'h11, 1);
        wr(12'h501, 32'h22, 2'b00); apply(1, 32'h22, 1);
        wr(12'h502, 32'h33, 2'b00); apply(2, 32'h33, 1);
        cmd(8'hD0);
        busy(n);
        chk("R3 confirm after masked count", 32'(n), BLK);
        for (int i = 0; i < BLK; i++) exp_mem[12'h500 + i] = tbuf[i];
        cmp_blk("R3 block", 12'h500);

        // R5 R9: out-of-block writes, then confirm with error set
        start_blk(12'h200, 32'd1, n);
        wr(12'h1FF, 32'h99, 2'b00);
        chk("R5 below base error", bus_rdata, 32'h90);
        wr(12'h20E, 32'hCAFEBABE, 2'b10);
        chk("R5 past end error", bus_rdata, 32'h90);
        cmd(8'hD0);
        busy(n);
        chk("R9 no write-back", 32'(n), 0);
        cmp_blk("R9 array unchanged", 12'h200);
        rd(12'h203, v);
        chk("R9 array mode", 32'(v), 32'(pat(12'h203)));
        cmd(8'h70);
        chk("R5 error sticky", bus_rdata, 32'h90);
        cmd(8'h50);
        chk("R11 clear error", bus_rdata, 32'h80);

        // R8: abort with a non-confirm write
        start_blk(12'h300, 32'd0, n);
        wr(12'h300, 32'hEE, 2'b00);
        cmd(8'h70);
        busy(n);
        chk("R8 no write-back", 32'(n), 0);
        rd(12'h300, v);
        chk("R8 array mode and unchanged", 32'(v), 32'(pat(12'h300)));
        cmp_blk("R8 block", 12'h300);

        // R10: write protect
        wp = 1'b1;
        start_blk(12'h400, 32'd0, n);
        wr(12'h401, 32'h44, 2'b00);
        chk("R10 error on protected write", bus_rdata, 32'h90);
        cmd(8'hD0);
        wp = 1'b0;
        cmp_blk("R10 array unchanged", 12'h400);
        cmd(8'h70);
        cmd(8'h50);
        chk("R11 status mode clear", bus_rdata, 32'h80);
        cmd(8'hFF);
        rd(12'h401, v);
        chk("R11 array mode", 32'(v), 32'(pat(12'h401)));

        // Random bursts, all inside their blocks
        for (int it = 0; it < 40; it++) begin
            logic [AW-1:0] b;
            int cnt;
            bit commit;
            b = {8'($urandom), 4'h0};
            cnt = int'($urandom % 4);
            start_blk(b | AW'($urandom % BLK), 32'(cnt), n);
            chk("R2 random fill stall", 32'(n), BLK);
            for (int w = 0; w <= cnt; w++) begin
                logic [1:0] s;
                int nb, off;
                logic [31:0] d;
                s = 2'($urandom % 4);
                nb = (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
                off = int'($urandom % (BLK + 1 - nb));
                d = $urandom;
                wr(b + AW'(off), d, s);
                apply(off, d, nb);
            end
            commit = 1'($urandom);
            if (commit) begin
                cmd(8'hD0);
                for (int i = 0; i < BLK; i++) exp_mem[int'(b) + i] = tbuf[i];
            end else begin
                cmd(8'hFF);
            end
            busy(n);
            cmp_blk(commit ? "R7 random commit" : "R8 random abort", b);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule